// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides an input clock, standing for a VCO signal, by a programmable ratio of N+1, where N is a 14-bit value. The divider is built the way a synthesizer loop builds it. A dual-modulus prescaler model counts either P or P+1 input cycles. A main counter counts prescaler cycles, and a swallow counter decides how many of them use the longer modulus. The total ratio M = N+1 splits into A = M mod P and B = M div P, so that M = A·(P+1) + (B−A)·P.

A band input selects the modulus pair. High selects the wide band, with P = 63 (63/64). Low selects the narrow band, with P = 7 (7/8). The output gives one single-clock pulse per division cycle, which feeds a phase comparator.

Some ratios cannot be split, because B < A. The block flags these on `cfg_invalid` and falls back to a defined ratio, so it never stalls. A new N or band value takes effect only at the end of a complete output cycle.

Top module: `swallow_divider`

## Requirements
- R1: With `band_fm` = 1 (P = 63) and a splittable N, `div_pulse` rises once every N+1 clock cycles.
- R2: With `band_fm` = 0 (P = 7) and a splittable N, `div_pulse` rises once every N+1 clock cycles.
- R3: `div_pulse` is high for exactly one clock cycle per output cycle.
- R4: `cfg_invalid` is a register. One clock after inputs are applied, it is 1 when B = (N+1) div P is smaller than A = (N+1) mod P, using P of the applied band. Otherwise it is 0.
- R5: When a loaded configuration is unsplittable, the output period is P·max(B,1) clock cycles, and pulses continue.
- R6: `n_val` and `band_fm` are sampled only on the clock edge at which `div_pulse` is asserted. Changes between those edges, including changes that are reverted before the next such edge, do not alter the period in progress.
- R7: `rst` is synchronous and active-high. While it is asserted, `div_pulse` stays 0 and the configuration is taken from the inputs. The first pulse follows the M-th rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| n_val | input | 14 | Programmed value N; ratio is N+1 |
| band_fm | input | 1 | Modulus pair select: 1 = 63/64, 0 = 7/8 |
| div_pulse | output | 1 | One-cycle pulse per division cycle |
| cfg_invalid | output | 1 | Registered flag: applied N cannot be split for the applied band |

## Verification
The assertions assume that every loaded configuration obeys swallow count ≤ main count and main count ≥ 1. The splitter guarantees this for any input, including unsplittable values. The one-cycle pulse property relies on the shortest possible period being at least 7 clocks. The stimulus changes `n_val` and `band_fm` one time unit after a falling edge, never at a rising edge. This keeps the value sampled at each cycle-end edge well defined. The expected period of every cycle is taken from the inputs held at the falling edge on which the previous pulse is seen.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  typedef enum logic {
    BAND_AM = 1'b0,
    BAND_FM = 1'b1
  } band_e;
endpackage

// File: rtl/swdiv_split.sv
// Splits M = N+1 into swallow count A and main count B for the selected band.
module swdiv_split #(
  parameter int NW   = 14,
  parameter int P_LO = 7,
  parameter int P_HI = 63,
  parameter int MW   = NW + 1,
  parameter int SW   = $clog2(P_HI)
) (
  input  logic [NW-1:0] n_val,
  input  logic          fm_sel,
  output logic [SW-1:0] a_eff,
  output logic [MW-1:0] b_eff,
  output logic          bad
);
  logic [MW-1:0] m_val;
  logic [SW-1:0] a_opt [2];
  logic [MW-1:0] b_opt [2];
  logic [SW-1:0] a_raw;
  logic [MW-1:0] b_raw;

  assign m_val = MW'(n_val) + MW'(1);

  for (genvar g = 0; g < 2; g++) begin : g_band
    localparam int PM = (g == 0) ? P_LO : P_HI;
    assign b_opt[g] = m_val / MW'(PM);
    assign a_opt[g] = SW'(m_val % MW'(PM));
  end

  always_comb begin
    a_raw = a_opt[fm_sel];
    b_raw = b_opt[fm_sel];
    bad   = MW'(a_raw) > b_raw;
    a_eff = bad ? '0 : a_raw;
    b_eff = (b_raw == '0) ? MW'(1) : b_raw;
  end
endmodule

// File: rtl/swdiv_prescaler.sv
// Dual-modulus prescaler model: counts down from a reload value, ticks at zero.
module swdiv_prescaler #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] load_val,
  output logic          tick
);
  logic [PW-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= load_val;
    else             cnt <= cnt - PW'(1);
  end
endmodule

// File: rtl/swdiv_counters.sv
// Main and swallow counters; hold the active configuration for one output cycle.
module swdiv_counters
  import swdiv_pkg::*;
#(
  parameter int MW = 15,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [SW-1:0] a_new,
  input  logic [MW-1:0] b_new,
  input  logic          fm_new,
  output logic          cycle_end,
  output logic          nxt_swallow,
  output logic          nxt_fm
);
  logic [MW-1:0] main_cnt;
  logic [SW-1:0] sw_cnt;
  band_e         act_band;
  logic          load;

  assign cycle_end = !rst && tick && (main_cnt == MW'(1));
  assign load      = rst || cycle_end;

  always_ff @(posedge clk) begin
    if (load) begin
      sw_cnt   <= a_new;
      main_cnt <= b_new;
      act_band <= band_e'(fm_new);
    end else if (tick) begin
      main_cnt <= main_cnt - MW'(1);
      if (sw_cnt != '0) sw_cnt <= sw_cnt - SW'(1);
    end
  end

  always_comb begin
    if (load) begin
      nxt_fm      = fm_new;
      nxt_swallow = (a_new != '0);
    end else begin
      nxt_fm      = (act_band == BAND_FM);
      nxt_swallow = (sw_cnt > SW'(1));
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int NW   = 14,
  parameter int P_LO = 7,
  parameter int P_HI = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_val,
  input  logic          band_fm,
  output logic          div_pulse,
  output logic          cfg_invalid
);
  localparam int MW = NW + 1;
  localparam int SW = $clog2(P_HI);
  localparam int PW = $clog2(P_HI + 1);

  logic [SW-1:0] a_eff;
  logic [MW-1:0] b_eff;
  logic          bad;
  logic          tick;
  logic          cycle_end;
  logic          nxt_swallow;
  logic          nxt_fm;
  logic [PW-1:0] load_val;

  swdiv_split #(.NW(NW), .P_LO(P_LO), .P_HI(P_HI), .MW(MW), .SW(SW)) u_split (
    .n_val (n_val),
    .fm_sel(band_fm),
    .a_eff (a_eff),
    .b_eff (b_eff),
    .bad   (bad)
  );

  swdiv_counters #(.MW(MW), .SW(SW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .a_new      (a_eff),
    .b_new      (b_eff),
    .fm_new     (band_fm),
    .cycle_end  (cycle_end),
    .nxt_swallow(nxt_swallow),
    .nxt_fm     (nxt_fm)
  );

  // Reload value is modulus minus one: P for a swallowed cycle (P+1 clocks), else P-1.
  always_comb begin
    if (nxt_fm) load_val = nxt_swallow ? PW'(P_HI) : PW'(P_HI - 1);
    else        load_val = nxt_swallow ? PW'(P_LO) : PW'(P_LO - 1);
  end

  swdiv_prescaler #(.PW(PW)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .load_val(load_val),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= cycle_end;
    cfg_invalid <= bad;
  end
endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker #(
  parameter int MW = 15,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          div_pulse,
  input logic          tick,
  input logic          cycle_end,
  input logic [MW-1:0] main_cnt,
  input logic [SW-1:0] sw_cnt,
  input logic          act_fm
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse); // R3

  AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> div_pulse); // R1

  AST_MAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !cycle_end) |=> (main_cnt == $past(main_cnt) - MW'(1))); // R2

  AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    main_cnt != '0); // R5

  AST_SWALLOW_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    MW'(sw_cnt) <= main_cnt); // R5

  AST_BAND_HELD: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(act_fm)); // R6
endmodule

bind swallow_divider swdiv_checker #(.MW(MW), .SW(SW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .div_pulse(div_pulse),
  .tick     (tick),
  .cycle_end(cycle_end),
  .main_cnt (u_cnt.main_cnt),
  .sw_cnt   (u_cnt.sw_cnt),
  .act_fm   (u_cnt.act_band)
);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] n_val;
  logic        band_fm;
  logic        div_pulse;
  logic        cfg_invalid;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    exp_q[$];
  string tag_q[$];
  string cur_tag  = "R7";
  int    edge_cnt = 0;
  bit    prev_pulse = 1'b0;

  always #5 clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rst(rst), .n_val(n_val), .band_fm(band_fm),
    .div_pulse(div_pulse), .cfg_invalid(cfg_invalid)
  );

  function automatic int exp_period(int n, bit fm);
    int m = n + 1;
    int p = fm ? 63 : 7;
    int b = m / p;
    int a = m % p;
    if (b < a) return p * ((b == 0) ? 1 : b);
    return m;
  endfunction

  function automatic bit exp_bad(int n, bit fm);
    int m = n + 1;
    int p = fm ? 63 : 7;
    return (m / p) < (m % p);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Predictor and monitor: at each pulse, compare the finished period and
  // queue the expectation for the period that has just started.
  always @(negedge clk) begin
    if (rst) begin
      exp_q.delete();
      tag_q.delete();
      exp_q.push_back(exp_period(int'(n_val), band_fm));
      tag_q.push_back(cur_tag);
      edge_cnt   = 0;
      prev_pulse = 1'b0;
    end else begin
      edge_cnt++;
      if (prev_pulse) check(!div_pulse, "R3", int'(div_pulse), 0);
      if (div_pulse) begin
        if (exp_q.size() > 0) begin
          check(edge_cnt == exp_q[0], tag_q[0], edge_cnt, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        exp_q.push_back(exp_period(int'(n_val), band_fm));
        tag_q.push_back(cur_tag);
        edge_cnt = 0;
      end
      prev_pulse = div_pulse;
    end
  end

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
    #1;
  endtask

  task automatic hold(int k);
    for (int i = 0; i < k; i++) wait_pulse();
  endtask

  // Drive a configuration (called one time unit after a falling edge) and check R4.
  task automatic set_cfg(int n, bit fm, string tag);
    n_val   = 14'(n);
    band_fm = fm;
    cur_tag = tag;
    @(negedge clk);
    check(cfg_invalid == exp_bad(n, fm), "R4", int'(cfg_invalid), int'(exp_bad(n, fm)));
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst     = 1'b1;
    n_val   = 14'd3999;
    band_fm = 1'b1;
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R7", int'(div_pulse), 0);
    check(cfg_invalid == 1'b0, "R7", int'(cfg_invalid), 0);
    #1 rst = 1'b0;
    wait_pulse();           // first period after reset, tagged R7
    cur_tag = "R1";
    hold(1);

    // R1: wide band, splittable values including both ends of the range
    set_cfg(62, 1'b1, "R1");    hold(2);
    set_cfg(63, 1'b1, "R1");    hold(2);
    set_cfg(16383, 1'b1, "R1"); hold(2);

    // R2: narrow band
    set_cfg(99, 1'b0, "R2");    hold(2);
    set_cfg(6, 1'b0, "R2");     hold(2);
    set_cfg(7, 1'b0, "R2");     hold(2);
    set_cfg(16383, 1'b0, "R2"); hold(2);

    // R5: unsplittable values keep pulsing with period P*max(B,1)
    set_cfg(9, 1'b1, "R5");     hold(2);
    set_cfg(1000, 1'b1, "R5");  hold(2);
    set_cfg(0, 1'b0, "R5");     hold(2);
    set_cfg(12, 1'b0, "R5");    hold(2);

    // R6: a change in mid-cycle only applies from the next cycle end
    set_cfg(99, 1'b0, "R6");    hold(2);
    repeat (30) @(negedge clk);
    #1;
    set_cfg(62, 1'b1, "R6");    hold(3);
    // R6: a change reverted before the cycle end has no effect
    repeat (10) @(negedge clk);
    #1;
    set_cfg(5000, 1'b0, "R6");
    repeat (5) @(negedge clk);
    #1;
    set_cfg(62, 1'b1, "R6");    hold(3);

    finish_run();
  end
endmodule